// File: doc/BRIEF.md
# Single-Precision Underflow and Flush-to-Zero Rounding Stage

This block is the last stage of a single-precision floating-point datapath. An upstream unit hands it a result that has not yet been rounded: a sign, a signed biased exponent wider than the final eight-bit field, a normalized 24-bit significand (hidden bit included), and a guard bit plus a sticky bit that capture everything below the significand. The stage decides whether the exact value lies below the smallest normal number, checking before any rounding. It then either rounds the value to nearest-even in normal form, shifts it into subnormal form and rounds it there, or replaces it with a signed zero when flush-to-zero is selected.

The packed 32-bit word appears one clock after the operand is accepted. Underflow and inexact status bits collect events across operations until a clear input resets them. Tiny results raise underflow only when they lose precision. Under flush-to-zero every tiny result raises it. Overflow to infinity, NaN inputs and rounding modes other than nearest-even are left to other stages.

Top module: `fp_underflow_round`

## Requirements
- R1: An operand presented with `in_valid` high produces `out_result` one clock later, with `out_valid` high in that cycle. While `in_valid` is low, `out_result` keeps its last value.
- R2: The input value is (-1)^`in_sign` × `in_sig`/2^23 × 2^(`in_exp`−127), with `in_sig[23]` set for any nonzero value. An all-zero `in_sig` yields a signed zero (`out_result` = sign in bit 31, all other bits 0) and raises no flag.
- R3: A nonzero input with `in_exp` ≥ 1 is not tiny. It is rounded to nearest-even using guard, sticky and the significand LSB, and packed as sign in bit 31, exponent field `in_exp` in bits 30:23 and the low 23 significand bits in 22:0. A rounding carry increments the exponent field. Underflow is not raised.
- R4: A nonzero input with `in_exp` ≤ 0 is tiny. The decision is made on the unrounded value.
- R5: With `ftz_en` low, a tiny input is shifted right by (1 − `in_exp`) places, and every bit shifted out joins the sticky bit. It is then rounded to nearest-even with exponent field 0. Shifts past the whole significand leave only sticky.
- R6: A subnormal whose rounding carries into the hidden bit is delivered as the smallest normal value (exponent field 1, fraction 0). It still counts as tiny.
- R7: With `ftz_en` low, a tiny input raises underflow only if its delivered result is inexact.
- R8: With `ftz_en` high, a tiny input delivers a zero of the same sign and raises both underflow and inexact. Non-tiny inputs are unaffected by `ftz_en`.
- R9: Inexact is raised whenever guard or sticky is nonzero after alignment, that is, whenever the delivered value differs from the exact one.
- R10: `out_uf` and `out_ix` are sticky and clear only when `flag_clr` is high. An event in the same cycle as `flag_clr` is still recorded.
- R11: Bit 31 of every delivered result equals the input sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Sign of the unrounded result |
| in_exp | input | EXP_W | Signed biased exponent |
| in_sig | input | 24 | Normalized significand, hidden bit at 23 |
| in_guard | input | 1 | First bit below the significand |
| in_sticky | input | 1 | OR of all lower bits |
| ftz_en | input | 1 | Flush tiny results to zero |
| flag_clr | input | 1 | Clear the sticky status bits |
| out_valid | output | 1 | Result register was loaded last cycle |
| out_result | output | 32 | Packed single-precision result |
| out_uf | output | 1 | Sticky underflow status |
| out_ix | output | 1 | Sticky inexact status |

## Verification
On every cycle, the bound checker enforces the one-cycle result timing and the holding of the result register. It also checks that the sign is preserved and that flushed tiny results come out as signed zeros with underflow raised. Further cycle-by-cycle properties cover the exponent field (at least 1 for non-tiny values, at most 1 for denormalized ones) and the sticky hold and clear of the status bits. The exact rounded bit patterns can only be shown by the directed scenarios. These cover ties to even, carries into the exponent, carries from subnormal into normal form, very deep shifts and the exact-but-tiny case that must leave underflow clear.

// File: rtl/fpur_pkg.sv
package fpur_pkg;
  localparam int FRAC_W  = 23;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int EFLD_W  = 8;
  localparam int WORD_W  = 1 + EFLD_W + FRAC_W;

  typedef struct packed {
    logic              sign;
    logic [EFLD_W-1:0] efld;
    logic [FRAC_W-1:0] frac;
  } fp_word_t;
endpackage

// File: rtl/fpur_align.sv
module fpur_align
  import fpur_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  input  logic                    guard_i,
  input  logic                    sticky_i,
  output logic [SIG_W-1:0]        sig_o,
  output logic                    guard_o,
  output logic                    sticky_o,
  output logic                    tiny_o,
  output logic                    zero_o
);
  localparam int MW = SIG_W + 1;

  logic [MW-1:0] full_w;
  logic [MW-1:0] shifted_w;
  logic          lost_w;
  int            shamt;

  always_comb begin
    zero_o = (sig_i == '0);
    tiny_o = !zero_o && (exp_i <= 0);
    shamt  = tiny_o ? (1 - int'(exp_i)) : 0;
    if (shamt > MW) shamt = MW;
    full_w    = {sig_i, guard_i};
    shifted_w = full_w >> shamt;
    lost_w    = 1'b0;
    for (int i = 0; i < MW; i++) begin
      if (i < shamt) lost_w = lost_w | full_w[i];
    end
    sig_o    = shifted_w[MW-1:1];
    guard_o  = zero_o ? 1'b0 : shifted_w[0];
    sticky_o = zero_o ? 1'b0 : (sticky_i | lost_w);
  end
endmodule

// File: rtl/fpur_rne.sv
module fpur_rne
  import fpur_pkg::*;
(
  input  logic              sign_i,
  input  logic [EFLD_W-1:0] efld_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              guard_i,
  input  logic              sticky_i,
  output fp_word_t          word_o,
  output logic              inexact_o
);
  localparam int MAG_W = EFLD_W + FRAC_W;

  logic             bump;
  logic [MAG_W-1:0] mag;

  always_comb begin
    bump      = guard_i & (sticky_i | frac_i[0]);
    mag       = {efld_i, frac_i} + {{(MAG_W-1){1'b0}}, bump};
    word_o    = {sign_i, mag};
    inexact_o = guard_i | sticky_i;
  end
endmodule

// File: rtl/fp_underflow_round.sv
module fp_underflow_round
  import fpur_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0]        in_sig,
  input  logic                    in_guard,
  input  logic                    in_sticky,
  input  logic                    ftz_en,
  input  logic                    flag_clr,
  output logic                    out_valid,
  output logic [WORD_W-1:0]       out_result,
  output logic                    out_uf,
  output logic                    out_ix
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [SIG_W-1:0]  al_sig;
  logic              al_g, al_s, is_tiny, is_zero;
  logic [EFLD_W-1:0] efld_sel;
  fp_word_t          rnd_word;
  logic              rnd_ix;

  fpur_align #(.EXP_W(EXP_W)) u_align (
    .exp_i(in_exp), .sig_i(in_sig), .guard_i(in_guard), .sticky_i(in_sticky),
    .sig_o(al_sig), .guard_o(al_g), .sticky_o(al_s),
    .tiny_o(is_tiny), .zero_o(is_zero)
  );

  assign efld_sel = (is_tiny || is_zero) ? '0 : in_exp[EFLD_W-1:0];

  fpur_rne u_rne (
    .sign_i(in_sign), .efld_i(efld_sel), .frac_i(al_sig[FRAC_W-1:0]),
    .guard_i(al_g), .sticky_i(al_s), .word_o(rnd_word), .inexact_o(rnd_ix)
  );

  logic            flush;
  logic            ev_uf, ev_ix;
  fp_word_t        res_d;
  logic            uf_d, ix_d;
  fp_word_t        res_q;
  logic            valid_q, uf_q, ix_q;

  always_comb begin
    flush = ftz_en & is_tiny;
    res_d = flush ? fp_word_t'({in_sign, {(WORD_W-1){1'b0}}}) : rnd_word;
    ev_ix = in_valid & (flush | rnd_ix);
    ev_uf = in_valid & is_tiny & (flush | rnd_ix);
    uf_d  = (flag_clr ? 1'b0 : uf_q) | ev_uf;
    ix_d  = (flag_clr ? 1'b0 : ix_q) | ev_ix;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      uf_q    <= 1'b0;
      ix_q    <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) res_q <= res_d;
      uf_q <= uf_d;
      ix_q <= ix_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_result = res_q;
  assign out_uf     = uf_q;
  assign out_ix     = ix_q;
endmodule

// File: rtl/fpur_chk.sv
module fpur_chk #(
  parameter int EXP_W = 10
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic                    in_valid,
  input logic                    in_sign,
  input logic signed [EXP_W-1:0] in_exp,
  input logic [23:0]             in_sig,
  input logic                    ftz_en,
  input logic                    flag_clr,
  input logic                    out_valid,
  input logic [31:0]             out_result,
  input logic                    out_uf,
  input logic                    out_ix
);
  logic in_tiny, in_big;
  assign in_tiny = (in_sig != 24'd0) && (in_exp <= 0);
  assign in_big  = (in_sig != 24'd0) && (in_exp > 0);

  // R1
  result_timing_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(out_result) && !out_valid);
  // R11
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_result[31] == $past(in_sign));
  // R8
  ftz_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid && ftz_en && in_tiny |=> out_result[30:0] == 31'd0 && out_uf && out_ix);
  // R3
  normal_efld_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid && in_big |=> out_result[30:23] != 8'd0);
  // R5
  subn_efld_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid && !ftz_en && in_tiny |=> out_result[30:23] <= 8'd1);
  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_uf && !flag_clr |=> out_uf);
  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_clr && !in_valid |=> !out_uf && !out_ix);
endmodule

bind fp_underflow_round fpur_chk #(.EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .in_valid(in_valid), .in_sign(in_sign),
  .in_exp(in_exp), .in_sig(in_sig), .ftz_en(ftz_en), .flag_clr(flag_clr),
  .out_valid(out_valid), .out_result(out_result), .out_uf(out_uf), .out_ix(out_ix)
);

// File: tb/fp_underflow_round_test.sv
module fp_underflow_round_test;
  localparam int EXP_W = 10;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    in_valid = 1'b0;
  logic                    in_sign = 1'b0;
  logic signed [EXP_W-1:0] in_exp = '0;
  logic [23:0]             in_sig = '0;
  logic                    in_guard = 1'b0;
  logic                    in_sticky = 1'b0;
  logic                    ftz_en = 1'b0;
  logic                    flag_clr = 1'b0;
  logic                    out_valid;
  logic [31:0]             out_result;
  logic                    out_uf, out_ix;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fp_underflow_round #(.EXP_W(EXP_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_sig(in_sig), .in_guard(in_guard), .in_sticky(in_sticky),
    .ftz_en(ftz_en), .flag_clr(flag_clr), .out_valid(out_valid),
    .out_result(out_result), .out_uf(out_uf), .out_ix(out_ix)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic op(string req, bit sg, int e, logic [23:0] sig, bit g, bit s,
                    bit ftz, bit clr, logic [31:0] x_res, bit x_uf, bit x_ix);
    @(negedge clk);
    in_valid = 1'b1; in_sign = sg; in_exp = EXP_W'(e); in_sig = sig;
    in_guard = g; in_sticky = s; ftz_en = ftz; flag_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
    check(req, "valid", {31'd0, out_valid}, 32'd1);
    check(req, "result", out_result, x_res);
    check(req, "uf", {31'd0, out_uf}, {31'd0, x_uf});
    check(req, "ix", {31'd0, out_ix}, {31'd0, x_ix});
  endtask

  task automatic t_reset;
    check("R1", "reset valid", {31'd0, out_valid}, 32'd0);
    check("R1", "reset result", out_result, 32'd0);
    check("R10", "reset flags", {30'd0, out_uf, out_ix}, 32'd0);
  endtask

  task automatic t_normal;
    op("R3", 0, 127, 24'h800000, 0, 0, 0, 1, 32'h3F800000, 0, 0);
    op("R3", 0, 127, 24'h800001, 1, 0, 0, 1, 32'h3F800002, 0, 1);
    op("R9", 0, 127, 24'h800000, 1, 0, 0, 1, 32'h3F800000, 0, 1);
    op("R3", 0, 127, 24'hFFFFFF, 1, 0, 0, 1, 32'h40000000, 0, 1);
    op("R8", 0, 1, 24'h800000, 0, 0, 1, 1, 32'h00800000, 0, 0);
  endtask

  task automatic t_tiny;
    op("R7", 0, 0, 24'h800000, 0, 0, 0, 1, 32'h00400000, 0, 0);
    op("R5", 0, 0, 24'h800001, 0, 0, 0, 1, 32'h00400000, 1, 1);
    op("R6", 1, 0, 24'hFFFFFF, 1, 0, 0, 1, 32'h80800000, 1, 1);
    op("R5", 0, -22, 24'h800000, 0, 0, 0, 1, 32'h00000001, 0, 0);
    op("R5", 0, -23, 24'h800000, 0, 0, 0, 1, 32'h00000000, 1, 1);
    op("R5", 0, -23, 24'h800000, 0, 1, 0, 1, 32'h00000001, 1, 1);
    op("R4", 1, -300, 24'h800000, 0, 0, 0, 1, 32'h80000000, 1, 1);
  endtask

  task automatic t_ftz;
    op("R8", 1, 0, 24'h800000, 0, 0, 1, 1, 32'h80000000, 1, 1);
    op("R11", 0, -5, 24'h812345, 1, 1, 1, 1, 32'h00000000, 1, 1);
  endtask

  task automatic t_zero;
    op("R2", 1, -5, 24'h000000, 0, 0, 0, 1, 32'h80000000, 0, 0);
    op("R2", 0, 50, 24'h000000, 0, 0, 1, 1, 32'h00000000, 0, 0);
  endtask

  task automatic t_sticky;
    op("R10", 0, 0, 24'h800001, 0, 0, 0, 1, 32'h00400000, 1, 1);
    op("R10", 0, 127, 24'h800000, 0, 0, 0, 0, 32'h3F800000, 1, 1);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R10", "cleared flags", {30'd0, out_uf, out_ix}, 32'd0);
    check("R1", "held result", out_result, 32'h3F800000);
    check("R1", "idle valid", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_normal();
    t_tiny();
    t_ftz();
    t_zero();
    t_sticky();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule